// File: doc/BRIEF.md
# Doorbell Mailbox with Circular Buffers and Host Control Register

This block is the device-side register file of a host-to-device mailbox on a 32-bit memory-mapped bus. The host pushes dwords into an outbound ring through a write window. It pulls dwords from an inbound ring through a read window. A control/status register reports the outbound ring's depth and pointers and carries the interrupt, doorbell, ready and reset controls. A fourth register reports the inbound ring's pointers and the device's ready state.

The device consumer attaches through a simple pop port on the outbound ring and a push port on the inbound ring, plus a ready level. Both rings use free-running 8-bit pointers. The fill level is their difference modulo 256, so host software can compute filled and free slots from a single register read. Device activity raises an interrupt status bit, and the host clears it by writing back the value it read.

Top module: `mbox_ring_csr`

## Requirements
- R1: After synchronous reset, the control register (word 1) reads `{DEPTH, 8'h00, 8'h00, 8'h00}`, the status register (word 3) reads `{DEPTH, 8'h00, 8'h00, 8'h00}`, and `irq`, `doorbell` and `dev_h2d_valid` are low.
- R2: Each host write to word 0 stores the dword at the outbound tail and adds 1 to the write pointer in bits 23:16 of word 1. The device sees the dwords in order on `dev_h2d_data` while `dev_h2d_valid` is high, and each `dev_pop` adds 1 to the read pointer in bits 15:8 of word 1. Reading word 0 returns zero.
- R3: The outbound fill level (write pointer minus read pointer, modulo 256) never exceeds DEPTH. A host write to word 0 at fill level DEPTH is dropped, leaves the pointers unchanged and sets the sticky error bit 5 of word 1, which host writes cannot clear.
- R4: Pointers wrap from 255 to 0, and the fill level stays correct across the wrap.
- R5: Bit 1 of word 1 (interrupt status) is write-one-to-clear, and writing 0 to it leaves it unchanged. Writing back the value just read clears a pending status and leaves bits 0, 3 and 4 at their read values.
- R6: Interrupt status is set one cycle after an accepted device pop, an accepted device push, or a change of `dev_ready`. When such an event coincides with a host clear, the set wins.
- R7: `irq` is high exactly when status bit 1 and enable bit 0 of word 1 are both set.
- R8: Writing 1 to bit 2 of word 1 (doorbell) makes bit 2 read 1 and `doorbell` high for exactly the next cycle. It then clears by itself.
- R9: Bit 3 of word 1 (host ready) takes the written value, except that any write with bit 4 (reset) set forces it to 0. Bit 3 reads 0 for as long as bit 4 is set.
- R10: A write with bit 4 set while bit 4 reads 0 empties the outbound ring (read pointer becomes write pointer) and clears the error bit. A write with bit 4 set while it is already set has no such effect. Writing 0 to bit 4 releases the reset.
- R11: A host read of word 2 returns the oldest inbound dword and adds 1 to the inbound read pointer. On an empty inbound ring it returns zero and changes nothing. `dev_push` at inbound fill level DEPTH is dropped, and `dev_d2h_full` reports that level.
- R12: Word 3 reports DEPTH in bits 31:24, the inbound write pointer in bits 23:16, the inbound read pointer in bits 15:8, and in bit 0 the value of `dev_ready` from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (side effect only on word 2) |
| host_addr | input | 2 | Word index: 0 push window, 1 control, 2 pop window, 3 status |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for the addressed word |
| irq | output | 1 | Interrupt request to host |
| doorbell | output | 1 | One-cycle pulse telling the device to look at the mailbox |
| dev_h2d_valid | output | 1 | Outbound ring holds data |
| dev_h2d_data | output | 32 | Oldest outbound dword |
| dev_pop | input | 1 | Device consumes the oldest outbound dword |
| dev_push | input | 1 | Device offers a dword to the inbound ring |
| dev_push_data | input | 32 | Dword offered by the device |
| dev_d2h_full | output | 1 | Inbound ring is full |
| dev_ready | input | 1 | Device ready level |

## Verification
The critical overlap is a host write to the control register that clears interrupt status landing in the same cycle as a device event that sets it. The set must win. A directed step drives a write-back clear together with an accepted `dev_pop`, and another drives it together with a toggle of `dev_ready`. The random phase keeps device pops, pushes and ready toggles running independently of host control writes, so further collisions occur. In every case the bench's model applies the set after the clear and compares bit 1 and `irq` on the next cycle.

// File: rtl/mbox_ring_pkg.sv
package mbox_ring_pkg;

    localparam int PTR_W = 8;

    typedef logic [PTR_W-1:0] ptr_t;

    typedef enum logic [1:0] {
        WIN_PUSH  = 2'd0,
        REG_CTRL  = 2'd1,
        WIN_POP   = 2'd2,
        REG_DSTAT = 2'd3
    } word_sel_e;

    // control field, bit 0 upward: ie, is, ig, rdy, rst, err
    typedef struct packed {
        logic err;
        logic rst;
        logic rdy;
        logic ig;
        logic is;
        logic ie;
    } ctrl_bits_t;

    function automatic logic [31:0] pack_word(logic [7:0] depth, ptr_t wp, ptr_t rp, logic [7:0] low);
        return {depth, wp, rp, low};
    endfunction

endpackage

// File: rtl/mbox_ring_fifo.sv
module mbox_ring_fifo
    import mbox_ring_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output ptr_t         wp,
    output ptr_t         rp,
    output logic         full,
    output logic         empty,
    output logic         push_ok,
    output logic         pop_ok
);
    // DEPTH must be a power of two between 2 and 128
    localparam int   IDX_W  = $clog2(DEPTH);
    localparam ptr_t DEPTHP = ptr_t'(DEPTH);

    logic [W-1:0] slots [DEPTH];
    ptr_t wp_q, rp_q, level;

    assign level   = wp_q - rp_q;
    assign empty   = (level == '0);
    assign full    = (level == DEPTHP);
    assign push_ok = push & ~full;
    assign pop_ok  = pop & ~empty & ~flush;
    assign head    = empty ? '0 : slots[rp_q[IDX_W-1:0]];
    assign wp      = wp_q;
    assign rp      = rp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            if (push_ok) wp_q <= wp_q + ptr_t'(1);
            if (flush)       rp_q <= wp_q;
            else if (pop_ok) rp_q <= rp_q + ptr_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) slots[wp_q[IDX_W-1:0]] <= push_data;
    end

    assert_level_bound_R3: assert property (@(posedge clk) disable iff (rst)
        level <= DEPTHP);
    assert_full_drop_R3: assert property (@(posedge clk) disable iff (rst)
        (push && full) |=> $stable(wp_q));
    assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        pop_ok |=> (rp_q == $past(rp_q) + ptr_t'(1)));
    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (rst)
        (flush && !push) |=> empty);

endmodule

// File: rtl/mbox_host_csr.sv
module mbox_host_csr
    import mbox_ring_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [4:0] wbits,
    input  logic       ev_pop,
    input  logic       ev_push,
    input  logic       push_drop,
    input  logic       dev_ready,
    output ctrl_bits_t ctl,
    output logic       dev_rdy_q,
    output logic       flush,
    output logic       irq,
    output logic       doorbell
);
    ctrl_bits_t ctl_q;
    logic       dr_q;
    logic       ev;

    assign ev       = ev_pop | ev_push | (dev_ready ^ dr_q);
    assign flush    = wr & wbits[4] & ~ctl_q.rst;
    assign irq      = ctl_q.is & ctl_q.ie;
    assign doorbell = ctl_q.ig;
    assign ctl      = ctl_q;
    assign dev_rdy_q = dr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            dr_q  <= 1'b0;
        end else begin
            dr_q     <= dev_ready;
            ctl_q.ig <= wr & wbits[2];
            if (wr) begin
                ctl_q.ie  <= wbits[0];
                ctl_q.rdy <= wbits[3] & ~wbits[4];
                ctl_q.rst <= wbits[4];
            end
            if (ev)                  ctl_q.is <= 1'b1;
            else if (wr && wbits[1]) ctl_q.is <= 1'b0;
            if (flush)          ctl_q.err <= 1'b0;
            else if (push_drop) ctl_q.err <= 1'b1;
        end
    end

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        ev |=> ctl_q.is);
    assert_w1c_R5: assert property (@(posedge clk) disable iff (rst)
        (wr && wbits[1] && !ev) |=> !ctl_q.is);
    assert_doorbell_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        !(wr && wbits[2]) |=> !ctl_q.ig);
    assert_rdy_low_in_reset_R9: assert property (@(posedge clk) disable iff (rst)
        ctl_q.rst |-> !ctl_q.rdy);
    assert_err_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.err && !flush) |=> ctl_q.err);

endmodule

// File: rtl/mbox_ring_csr.sv
module mbox_ring_csr
    import mbox_ring_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [1:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        irq,
    output logic        doorbell,
    output logic        dev_h2d_valid,
    output logic [31:0] dev_h2d_data,
    input  logic        dev_pop,
    input  logic        dev_push,
    input  logic [31:0] dev_push_data,
    output logic        dev_d2h_full,
    input  logic        dev_ready
);
    localparam logic [7:0] DEPTH8 = 8'(DEPTH);

    word_sel_e  sel;
    ctrl_bits_t ctl;
    ptr_t       h_wp, h_rp, d_wp, d_rp;
    logic       h_full, h_empty, h_push_ok, h_pop_ok;
    logic       d_empty, d_push_ok, d_pop_ok;
    logic       flush, dev_rdy_q, csr_wr, win_push, win_pop;
    logic [31:0] d_head;

    assign sel      = word_sel_e'(host_addr);
    assign csr_wr   = host_wr && (sel == REG_CTRL);
    assign win_push = host_wr && (sel == WIN_PUSH);
    assign win_pop  = host_rd && (sel == WIN_POP);

    mbox_ring_fifo #(.DEPTH(DEPTH), .W(32)) u_h2d (
        .clk(clk), .rst(rst), .flush(flush),
        .push(win_push), .push_data(host_wdata), .pop(dev_pop),
        .head(dev_h2d_data), .wp(h_wp), .rp(h_rp),
        .full(h_full), .empty(h_empty), .push_ok(h_push_ok), .pop_ok(h_pop_ok)
    );

    mbox_ring_fifo #(.DEPTH(DEPTH), .W(32)) u_d2h (
        .clk(clk), .rst(rst), .flush(1'b0),
        .push(dev_push), .push_data(dev_push_data), .pop(win_pop),
        .head(d_head), .wp(d_wp), .rp(d_rp),
        .full(dev_d2h_full), .empty(d_empty), .push_ok(d_push_ok), .pop_ok(d_pop_ok)
    );

    mbox_host_csr u_csr (
        .clk(clk), .rst(rst), .wr(csr_wr), .wbits(host_wdata[4:0]),
        .ev_pop(h_pop_ok), .ev_push(d_push_ok), .push_drop(win_push & h_full),
        .dev_ready(dev_ready), .ctl(ctl), .dev_rdy_q(dev_rdy_q),
        .flush(flush), .irq(irq), .doorbell(doorbell)
    );

    assign dev_h2d_valid = ~h_empty;

    always_comb begin
        case (sel)
            WIN_PUSH: host_rdata = '0;
            REG_CTRL: host_rdata = pack_word(DEPTH8, h_wp, h_rp, {2'b00, ctl});
            WIN_POP:  host_rdata = d_head;
            default:  host_rdata = pack_word(DEPTH8, d_wp, d_rp, {7'd0, dev_rdy_q});
        endcase
    end

    assert_empty_read_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (win_pop && d_empty) |-> (host_rdata == 32'd0 && !d_pop_ok));
    assert_push_advances_R2: assert property (@(posedge clk) disable iff (rst)
        h_push_ok |=> (h_wp == $past(h_wp) + ptr_t'(1)));

endmodule

// File: tb/mbox_ring_csr_bench.sv
module mbox_ring_csr_bench;
    localparam int DEP = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_wr, host_rd, dev_pop, dev_push, dev_ready;
    logic [1:0]  host_addr;
    logic [31:0] host_wdata, host_rdata, dev_h2d_data, dev_push_data;
    logic        irq, doorbell, dev_h2d_valid, dev_d2h_full;

    int n_chk = 0;
    int n_fail = 0;

    // model state
    logic [31:0] m_hq[$];
    logic [31:0] m_dq[$];
    int   m_hwp, m_hrp, m_dwp, m_drp;
    logic m_ie, m_is, m_ig, m_rdy, m_rst, m_err, m_devrdy;

    always #5 clk = ~clk;

    mbox_ring_csr #(.DEPTH(DEP)) u_mbox_ring_csr (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq(irq), .doorbell(doorbell), .dev_h2d_valid(dev_h2d_valid),
        .dev_h2d_data(dev_h2d_data), .dev_pop(dev_pop), .dev_push(dev_push),
        .dev_push_data(dev_push_data), .dev_d2h_full(dev_d2h_full), .dev_ready(dev_ready)
    );

    function automatic logic [31:0] exp_ctrl();
        return {8'(DEP), 8'(m_hwp), 8'(m_hrp), 2'b00, m_err, m_rst, m_rdy, m_ig, m_is, m_ie};
    endfunction

    function automatic logic [31:0] exp_stat();
        return {8'(DEP), 8'(m_dwp), 8'(m_drp), 7'd0, m_devrdy};
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic rd, input logic [1:0] a, input logic [31:0] wd,
                        input logic pop, input logic push, input logic [31:0] pd,
                        input logic dr, input string tag);
        logic [31:0] er;
        string t;
        logic hflush, hs_ok, dp_ok, hp_ok, dr_ok, ev;
        host_wr = wr; host_rd = rd; host_addr = a; host_wdata = wd;
        dev_pop = pop; dev_push = push; dev_push_data = pd; dev_ready = dr;
        #1;
        case (a)
            2'd0: er = 32'd0;
            2'd1: er = exp_ctrl();
            2'd2: er = (m_dq.size() > 0) ? m_dq[0] : 32'd0;
            default: er = exp_stat();
        endcase
        if (tag != "") t = tag;
        else t = (a == 2'd0) ? "R2" : (a == 2'd1) ? "R9" : (a == 2'd2) ? "R11" : "R12";
        check(t, "host_rdata", host_rdata, er);
        check("R7", "irq", {31'd0, irq}, {31'd0, m_is & m_ie});
        check("R8", "doorbell", {31'd0, doorbell}, {31'd0, m_ig});
        check("R2", "h2d_valid", {31'd0, dev_h2d_valid}, {31'd0, m_hq.size() > 0});
        if (m_hq.size() > 0) check("R2", "h2d_data", dev_h2d_data, m_hq[0]);
        check("R11", "d2h_full", {31'd0, dev_d2h_full}, {31'd0, m_dq.size() == DEP});
        @(posedge clk);
        hflush = wr && a == 2'd1 && wd[4] && !m_rst;
        hs_ok  = wr && a == 2'd0 && m_hq.size() < DEP;
        dp_ok  = pop && m_hq.size() > 0 && !hflush;
        hp_ok  = push && m_dq.size() < DEP;
        dr_ok  = rd && a == 2'd2 && m_dq.size() > 0;
        ev     = dp_ok || hp_ok || (dr != m_devrdy);
        if (dp_ok) begin void'(m_hq.pop_front()); m_hrp = (m_hrp + 1) % 256; end
        if (hflush) begin m_hq.delete(); m_hrp = m_hwp; m_err = 1'b0; end
        if (hs_ok) begin m_hq.push_back(wd); m_hwp = (m_hwp + 1) % 256; end
        else if (wr && a == 2'd0) m_err = 1'b1;
        if (dr_ok) begin void'(m_dq.pop_front()); m_drp = (m_drp + 1) % 256; end
        if (hp_ok) begin m_dq.push_back(pd); m_dwp = (m_dwp + 1) % 256; end
        if (wr && a == 2'd1) begin
            m_ie = wd[0]; m_ig = wd[2]; m_rdy = wd[3] & ~wd[4]; m_rst = wd[4];
        end else m_ig = 1'b0;
        if (ev) m_is = 1'b1;
        else if (wr && a == 2'd1 && wd[1]) m_is = 1'b0;
        m_devrdy = dr;
        @(negedge clk);
    endtask

    task automatic idle_read(input logic [1:0] a, input string tag);
        step(1'b0, 1'b1, a, 32'd0, 1'b0, 1'b0, 32'd0, m_devrdy, tag);
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int seed;
        seed = 32'h1F2E;
        void'($urandom(seed));
        rst = 1'b1; host_wr = 0; host_rd = 0; host_addr = 0; host_wdata = 0;
        dev_pop = 0; dev_push = 0; dev_push_data = 0; dev_ready = 0;
        m_hwp = 0; m_hrp = 0; m_dwp = 0; m_drp = 0;
        m_ie = 0; m_is = 0; m_ig = 0; m_rdy = 0; m_rst = 0; m_err = 0; m_devrdy = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        idle_read(2'd1, "R1");
        idle_read(2'd3, "R1");

        // R3 fill past depth, overflow drop and sticky error
        for (int i = 0; i <= DEP; i++)
            step(1'b1, 1'b0, 2'd0, 32'hA000_0000 + i, 1'b0, 1'b0, 32'd0, 1'b0, "R3");
        idle_read(2'd1, "R3");
        step(1'b1, 1'b0, 2'd1, 32'h0000_0001, 1'b0, 1'b0, 32'd0, 1'b0, "R3");
        idle_read(2'd1, "R3");

        // R6 pop raises status, R5 write-back clears it
        step(1'b0, 1'b0, 2'd1, 32'd0, 1'b1, 1'b0, 32'd0, 1'b0, "R6");
        idle_read(2'd1, "R6");
        v = exp_ctrl();
        step(1'b1, 1'b0, 2'd1, v, 1'b0, 1'b0, 32'd0, 1'b0, "R5");
        idle_read(2'd1, "R5");
        step(1'b1, 1'b0, 2'd1, 32'h0000_0009, 1'b0, 1'b0, 32'd0, 1'b0, "R5");
        idle_read(2'd1, "R5");

        // R6 set wins over simultaneous clear: pop, then ready toggle
        step(1'b1, 1'b0, 2'd1, 32'h0000_0003, 1'b1, 1'b0, 32'd0, 1'b0, "R6");
        idle_read(2'd1, "R6");
        step(1'b1, 1'b0, 2'd1, 32'h0000_0003, 1'b0, 1'b0, 32'd0, 1'b1, "R6");
        idle_read(2'd1, "R6");
        idle_read(2'd3, "R12");

        // R8 doorbell pulse
        step(1'b1, 1'b0, 2'd1, 32'h0000_0004, 1'b0, 1'b0, 32'd0, 1'b1, "R8");
        idle_read(2'd1, "R8");
        idle_read(2'd1, "R8");

        // R9 ready set, forced low by reset; R10 flush only on first assertion
        step(1'b1, 1'b0, 2'd1, 32'h0000_0008, 1'b0, 1'b0, 32'd0, 1'b1, "R9");
        idle_read(2'd1, "R9");
        step(1'b1, 1'b0, 2'd1, 32'h0000_0018, 1'b0, 1'b0, 32'd0, 1'b1, "R10");
        idle_read(2'd1, "R10");
        step(1'b1, 1'b0, 2'd0, 32'h1111_0001, 1'b0, 1'b0, 32'd0, 1'b1, "R10");
        step(1'b1, 1'b0, 2'd0, 32'h1111_0002, 1'b0, 1'b0, 32'd0, 1'b1, "R10");
        step(1'b1, 1'b0, 2'd1, 32'h0000_0018, 1'b0, 1'b0, 32'd0, 1'b1, "R10");
        idle_read(2'd1, "R10");
        step(1'b1, 1'b0, 2'd1, 32'h0000_0008, 1'b0, 1'b0, 32'd0, 1'b1, "R10");
        idle_read(2'd1, "R9");

        // R11 inbound ring: empty read, fill to full, drop, drain
        idle_read(2'd2, "R11");
        idle_read(2'd3, "R11");
        for (int i = 0; i <= DEP; i++)
            step(1'b0, 1'b0, 2'd3, 32'd0, 1'b0, 1'b1, 32'hD000_0000 + i, 1'b1, "R12");
        for (int i = 0; i <= DEP; i++)
            idle_read(2'd2, "R11");
        idle_read(2'd3, "R12");

        // R4 pointer wrap on both rings
        for (int i = 0; i < 300; i++) begin
            step(1'b1, 1'b0, 2'd0, 32'hC000_0000 + i, 1'b1, 1'b1, 32'hE000_0000 + i, 1'b1, "R4");
            step(1'b0, 1'b1, 2'd2, 32'd0, 1'b0, 1'b0, 32'd0, 1'b1, "R4");
            if (i % 50 == 0) begin
                idle_read(2'd1, "R4");
                idle_read(2'd3, "R4");
            end
        end

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic wr, rd, pop, push, dr;
            logic [1:0] a;
            logic [31:0] wd;
            r = int'($urandom % 16);
            wr = 1'b0; rd = 1'b0; a = 2'($urandom); wd = $urandom;
            if (((i / 200) % 2) == 0 ? r < 6 : r < 2) begin wr = 1'b1; a = 2'd0; end
            else if (r < 8) begin rd = 1'b1; a = 2'd2; end
            else if (r < 10) begin
                wr = 1'b1; a = 2'd1;
                wd = wd & 32'h0000_002F;
                if ($urandom % 8 == 0) wd[4] = 1'b1;
            end else rd = 1'b1;
            pop  = ((i / 200) % 2) == 0 ? ($urandom % 4 == 0) : ($urandom % 2 == 0);
            push = ($urandom % 3 == 0);
            dr   = ($urandom % 16 == 0) ? ~m_devrdy : m_devrdy;
            step(wr, rd, a, wd, pop, push, $urandom, dr, "");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule